// File: doc/BRIEF.md
# Three-Access Stride Prefetcher

This block watches the stream of cache-block demand addresses coming out of a cache and proposes prefetches. In stride mode it keeps the two previous block addresses next to the incoming one. When the step from the oldest to the middle address equals the step from the middle to the newest, and that step is not zero, it requests the newest address plus the step. In next-block mode every demand address `a` starts a burst that proposes `a+1` through `a+NEXT_N`, one per free output slot.

Every proposal is compared against a small table of prefetches that are still in flight and against the one held at the output. A proposal that would repeat one of them is discarded. An entry joins the table when the downstream side accepts the prefetch, and it leaves when a completion carrying its address arrives. The output uses a valid/ready handshake. A prefetch still waiting when the next demand arrives is given up. Three counters measure effectiveness once the first `WARMUP` demands have trained the history.

Top module: `stride_prefetcher`

## Requirements
- R1: During and right after synchronous reset, `pf_valid` is 0 and all three counters are 0.
- R2: With `nextn_mode`=0, a demand `c` following demands `a`,`b` with `b-a == c-b != 0` (modulo 2^AW) raises `pf_valid` on the next cycle with `pf_addr = c+(c-b)`.
- R3: With `nextn_mode`=0, no prefetch is raised for a zero step, for unequal steps, or before two earlier demands have been seen since reset.
- R4: A proposal whose address equals an in-flight table entry, or the prefetch currently held at the output, is not issued.
- R5: A table entry is taken when `pf_valid && pf_ready`, and it is freed by `cpl_valid` with a matching `cpl_addr`. When all `TAB_DEPTH` entries are in use, no new prefetch is raised. After a completion frees an entry, the same address can be prefetched again.
- R6: While `pf_valid` is 1 and `pf_ready` is 0, with no demand arriving, `pf_valid` stays 1 and `pf_addr` stays unchanged.
- R7: A demand that arrives while a prefetch waits with `pf_ready`=0 discards it. In next-block mode, `pf_valid` is 0 in the following cycle.
- R8: With `nextn_mode`=1, a demand `a` proposes `a+1`..`a+NEXT_N` in order, one per cycle while the output slot is free. Proposals that repeat an in-flight prefetch are skipped, each using one step. A new demand restarts the burst.
- R9: The first `WARMUP` (6) demands after reset change no counter. Each later demand adds 1 to `total_cnt`.
- R10: A counted demand whose address matches an in-flight prefetch adds 1 to `covered_cnt`. It adds 1 to `useful_cnt` only on the first demand match for that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nextn_mode | input | 1 | 0 = stride detection, 1 = next-block bursts |
| dem_valid | input | 1 | Demand block address present |
| dem_addr | input | AW | Demand block address |
| cpl_valid | input | 1 | An outstanding request completed |
| cpl_addr | input | AW | Block address of the completion |
| pf_valid | output | 1 | Prefetch request present |
| pf_addr | output | AW | Prefetch block address |
| pf_ready | input | 1 | Downstream accepts the prefetch |
| total_cnt | output | CW | Demands counted after warm-up |
| covered_cnt | output | CW | Counted demands that matched an in-flight prefetch |
| useful_cnt | output | CW | In-flight prefetches matched by a demand at least once |

## Verification
The properties assume that a completion refers to a block that was actually issued, and that demand, completion and ready are clean one-bit levels sampled at the clock. They also assume the counters never wrap, so that the ordering between useful, covered and total matches holds. The stimulus sends each demand and completion as a single-cycle pulse on the falling edge. It completes only addresses it saw accepted at the output, and it stays far below the counter range. Ready is raised only for the cycles in which the test means to accept a prefetch. This lets held prefetches, table filling and burst skipping be observed cycle by cycle.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic {
    PF_STRIDE = 1'b0,
    PF_NEXTN  = 1'b1
  } pf_mode_e;
endpackage

// File: rtl/spf_history.sv
module spf_history #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dem_valid,
  input  logic [AW-1:0] dem_addr,
  output logic          cand_valid,
  output logic [AW-1:0] cand_addr
);
  logic [AW-1:0] h_new, h_old;
  logic [1:0]    depth;
  logic [AW-1:0] step_now, step_prev;

  assign step_now   = dem_addr - h_new;
  assign step_prev  = h_new - h_old;
  assign cand_valid = dem_valid && (depth == 2'd2) &&
                      (step_now == step_prev) && (step_now != '0);
  assign cand_addr  = dem_addr + step_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_new <= '0;
      h_old <= '0;
      depth <= '0;
    end else if (dem_valid) begin
      h_old <= h_new;
      h_new <= dem_addr;
      if (depth != 2'd2) depth <= depth + 2'd1;
    end
  end
endmodule

// File: rtl/spf_track_table.sv
module spf_track_table #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit,
  input  logic          dem_valid,
  input  logic [AW-1:0] dem_addr,
  output logic          dem_hit,
  output logic          dem_fresh,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic          cpl_valid,
  input  logic [AW-1:0] cpl_addr,
  output logic [FW-1:0] free_cnt
);
  logic [DEPTH-1:0]         vld, used;
  logic [DEPTH-1:0][AW-1:0] tag;
  logic [DEPTH-1:0]         probe_m, dem_m, cpl_m, ins_sel;

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign probe_m[i] = vld[i] && (tag[i] == probe_addr);
    assign dem_m[i]   = vld[i] && (tag[i] == dem_addr);
    assign cpl_m[i]   = vld[i] && (tag[i] == cpl_addr);
  end

  always_comb begin
    logic taken;
    taken   = 1'b0;
    ins_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i] && !taken) begin
        ins_sel[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

  assign probe_hit = |probe_m;
  assign dem_hit   = |dem_m;
  assign dem_fresh = |(dem_m & ~used);
  assign free_cnt  = FW'($countones(~vld));

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ins_valid && ins_sel[i]) tag[i] <= ins_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      used <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_valid && ins_sel[i]) begin
          vld[i]  <= 1'b1;
          used[i] <= 1'b0;
        end else if (cpl_valid && cpl_m[i]) begin
          vld[i]  <= 1'b0;
        end else if (dem_valid && dem_m[i]) begin
          used[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spf_stats.sv
module spf_stats #(
  parameter int CW     = 16,
  parameter int WARMUP = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dem_valid,
  input  logic          dem_hit,
  input  logic          dem_fresh,
  output logic [CW-1:0] total_cnt,
  output logic [CW-1:0] covered_cnt,
  output logic [CW-1:0] useful_cnt
);
  localparam int SW = $clog2(WARMUP + 1);
  logic [SW-1:0] seen;
  logic          trained;

  assign trained = (seen == SW'(WARMUP));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen        <= '0;
      total_cnt   <= '0;
      covered_cnt <= '0;
      useful_cnt  <= '0;
    end else if (dem_valid) begin
      if (!trained) begin
        seen <= seen + SW'(1);
      end else begin
        total_cnt <= total_cnt + CW'(1);
        if (dem_hit)   covered_cnt <= covered_cnt + CW'(1);
        if (dem_fresh) useful_cnt  <= useful_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int AW        = 16,
  parameter int TAB_DEPTH = 8,
  parameter int NEXT_N    = 3,
  parameter int CW        = 16,
  parameter int WARMUP    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nextn_mode,
  input  logic          dem_valid,
  input  logic [AW-1:0] dem_addr,
  input  logic          cpl_valid,
  input  logic [AW-1:0] cpl_addr,
  output logic          pf_valid,
  output logic [AW-1:0] pf_addr,
  input  logic          pf_ready,
  output logic [CW-1:0] total_cnt,
  output logic [CW-1:0] covered_cnt,
  output logic [CW-1:0] useful_cnt
);
  import spf_pkg::*;

  localparam int FW = $clog2(TAB_DEPTH + 1);
  localparam int KW = $clog2(NEXT_N + 1);

  pf_mode_e      mode;
  logic          cand_valid;
  logic [AW-1:0] cand_addr;
  logic          probe_hit, dem_hit, dem_fresh;
  logic [FW-1:0] free_cnt;
  logic          issue, slot_free, room, step;
  logic          sel_valid, dup, go;
  logic [AW-1:0] sel_addr;
  logic          bst_act;
  logic [AW-1:0] bst_base;
  logic [KW-1:0] bst_k;

  assign mode      = pf_mode_e'(nextn_mode);
  assign issue     = pf_valid && pf_ready;
  assign slot_free = !pf_valid || pf_ready;
  assign room      = free_cnt > FW'(issue);
  assign step      = !dem_valid && (mode == PF_NEXTN) && bst_act && slot_free;

  spf_history #(.AW(AW)) u_hist (
    .clk(clk), .rst(rst), .dem_valid(dem_valid), .dem_addr(dem_addr),
    .cand_valid(cand_valid), .cand_addr(cand_addr)
  );

  always_comb begin
    sel_valid = 1'b0;
    sel_addr  = cand_addr;
    if (dem_valid && mode == PF_STRIDE) begin
      sel_valid = cand_valid;
    end else if (step) begin
      sel_valid = 1'b1;
      sel_addr  = bst_base + AW'(bst_k);
    end
  end

  assign dup = probe_hit || (pf_valid && pf_addr == sel_addr);
  assign go  = sel_valid && !dup && room;

  spf_track_table #(.AW(AW), .DEPTH(TAB_DEPTH), .FW(FW)) u_tab (
    .clk(clk), .rst(rst),
    .probe_addr(sel_addr), .probe_hit(probe_hit),
    .dem_valid(dem_valid), .dem_addr(dem_addr),
    .dem_hit(dem_hit), .dem_fresh(dem_fresh),
    .ins_valid(issue), .ins_addr(pf_addr),
    .cpl_valid(cpl_valid), .cpl_addr(cpl_addr),
    .free_cnt(free_cnt)
  );

  spf_stats #(.CW(CW), .WARMUP(WARMUP)) u_stats (
    .clk(clk), .rst(rst), .dem_valid(dem_valid),
    .dem_hit(dem_hit), .dem_fresh(dem_fresh),
    .total_cnt(total_cnt), .covered_cnt(covered_cnt), .useful_cnt(useful_cnt)
  );

  // Output register: a held prefetch survives a demand only if that
  // demand proposes the very same block again.
  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (go) begin
      pf_valid <= 1'b1;
      pf_addr  <= sel_addr;
    end else if (issue) begin
      pf_valid <= 1'b0;
    end else if (dem_valid) begin
      pf_valid <= pf_valid && sel_valid && (pf_addr == sel_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bst_act  <= 1'b0;
      bst_base <= '0;
      bst_k    <= '0;
    end else if (dem_valid) begin
      bst_act  <= (mode == PF_NEXTN);
      bst_base <= dem_addr;
      bst_k    <= KW'(1);
    end else if (step) begin
      if (bst_k == KW'(NEXT_N)) bst_act <= 1'b0;
      else                      bst_k   <= bst_k + KW'(1);
    end else if (mode != PF_NEXTN) begin
      bst_act <= 1'b0;
    end
  end
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int AW        = 16,
  parameter int TAB_DEPTH = 8,
  parameter int NEXT_N    = 3,
  parameter int CW        = 16,
  parameter int WARMUP    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          nextn_mode,
  input logic          dem_valid,
  input logic [AW-1:0] dem_addr,
  input logic          cpl_valid,
  input logic [AW-1:0] cpl_addr,
  input logic          pf_valid,
  input logic [AW-1:0] pf_addr,
  input logic          pf_ready,
  input logic [CW-1:0] total_cnt,
  input logic [CW-1:0] covered_cnt,
  input logic [CW-1:0] useful_cnt
);
  localparam int SW = $clog2(WARMUP + 1);
  logic [SW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (dem_valid && seen != SW'(WARMUP)) seen <= seen + SW'(1);
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!pf_valid && total_cnt == '0 && covered_cnt == '0 && useful_cnt == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready && !dem_valid) |=> (pf_valid && $stable(pf_addr)));

  p_stall_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (nextn_mode && dem_valid && pf_valid && !pf_ready) |=> !pf_valid);

  p_no_repeat_r4: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_ready) |=> !(pf_valid && pf_addr == $past(pf_addr)));

  p_warmup_r9: assert property (@(posedge clk) disable iff (rst)
    (seen != SW'(WARMUP)) |-> (total_cnt == '0));

  p_count_order_r10: assert property (@(posedge clk) disable iff (rst)
    (useful_cnt <= covered_cnt) && (covered_cnt <= total_cnt));
endmodule

bind stride_prefetcher spf_checker #(
  .AW(AW), .TAB_DEPTH(TAB_DEPTH), .NEXT_N(NEXT_N), .CW(CW), .WARMUP(WARMUP)
) u_spf_checker (.*);

// File: tb/test_stride_prefetcher.sv
`timescale 1ns/1ps
module test_stride_prefetcher;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          nextn_mode = 1'b0;
  logic          dem_valid = 1'b0;
  logic [AW-1:0] dem_addr = '0;
  logic          cpl_valid = 1'b0;
  logic [AW-1:0] cpl_addr = '0;
  logic          pf_valid;
  logic [AW-1:0] pf_addr;
  logic          pf_ready = 1'b0;
  logic [CW-1:0] total_cnt, covered_cnt, useful_cnt;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  stride_prefetcher i_stride_prefetcher (
    .clk(clk), .rst(rst), .nextn_mode(nextn_mode),
    .dem_valid(dem_valid), .dem_addr(dem_addr),
    .cpl_valid(cpl_valid), .cpl_addr(cpl_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready),
    .total_cnt(total_cnt), .covered_cnt(covered_cnt), .useful_cnt(useful_cnt)
  );

  task automatic check_eq(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic demand(int a);
    @(negedge clk); dem_valid = 1'b1; dem_addr = AW'(a);
    @(negedge clk); dem_valid = 1'b0;
  endtask

  task automatic complete(int a);
    @(negedge clk); cpl_valid = 1'b1; cpl_addr = AW'(a);
    @(negedge clk); cpl_valid = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk); pf_ready = 1'b1;
    @(negedge clk); pf_ready = 1'b0;
  endtask

  task automatic t_reset();
    check_eq("R1 pf_valid", int'(pf_valid), 0);
    check_eq("R1 total", int'(total_cnt), 0);
    check_eq("R1 covered", int'(covered_cnt), 0);
    check_eq("R1 useful", int'(useful_cnt), 0);
  endtask

  task automatic t_stride_basic();
    demand(10);
    check_eq("R3 one access", int'(pf_valid), 0);
    demand(20);
    check_eq("R3 two accesses", int'(pf_valid), 0);
    demand(30);
    check_eq("R2 valid", int'(pf_valid), 1);
    check_eq("R2 addr", int'(pf_addr), 40);
    repeat (2) @(negedge clk);
    check_eq("R6 held valid", int'(pf_valid), 1);
    check_eq("R6 held addr", int'(pf_addr), 40);
    demand(35);
    check_eq("R7 R3 unequal steps drop", int'(pf_valid), 0);
    demand(40);
    check_eq("R2 second stride valid", int'(pf_valid), 1);
    check_eq("R2 second stride addr", int'(pf_addr), 45);
    accept();
    check_eq("R5 accepted", int'(pf_valid), 0);
  endtask

  task automatic t_dup_and_stats();
    demand(30);
    demand(35);
    demand(40);
    check_eq("R4 duplicate suppressed", int'(pf_valid), 0);
    demand(45);
    check_eq("R2 after dup valid", int'(pf_valid), 1);
    check_eq("R2 after dup addr", int'(pf_addr), 50);
    demand(45);
    check_eq("R3 zero step", int'(pf_valid), 0);
    check_eq("R9 total after warmup", int'(total_cnt), 4);
    check_eq("R10 covered", int'(covered_cnt), 2);
    check_eq("R10 useful once", int'(useful_cnt), 1);
  endtask

  task automatic t_completion();
    complete(45);
    demand(42);
    demand(43);
    demand(44);
    check_eq("R5 freed valid", int'(pf_valid), 1);
    check_eq("R5 freed addr", int'(pf_addr), 45);
    accept();
    demand(45);
    check_eq("R10 new entry covered", int'(covered_cnt), 3);
    check_eq("R10 new entry useful", int'(useful_cnt), 2);
    check_eq("R9 total", int'(total_cnt), 8);
    check_eq("R2 step one addr", int'(pf_addr), 46);
    accept();
    complete(45);
    complete(46);
  endtask

  task automatic t_next_n();
    @(negedge clk); nextn_mode = 1'b1; pf_ready = 1'b1;
    demand(100);
    check_eq("R8 burst start idle", int'(pf_valid), 0);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check_eq("R8 burst valid", int'(pf_valid), 1);
      check_eq("R8 burst addr", int'(pf_addr), 100 + k);
    end
    @(negedge clk);
    check_eq("R8 burst end", int'(pf_valid), 0);
    demand(101);
    @(negedge clk);
    check_eq("R8 R4 skip 102", int'(pf_valid), 0);
    @(negedge clk);
    check_eq("R8 R4 skip 103", int'(pf_valid), 0);
    @(negedge clk);
    check_eq("R8 after skips valid", int'(pf_valid), 1);
    check_eq("R8 after skips addr", int'(pf_addr), 104);
    check_eq("R10 next-block covered", int'(covered_cnt), 4);
    @(negedge clk);
    check_eq("R8 short burst end", int'(pf_valid), 0);
  endtask

  task automatic t_table_full();
    demand(200);
    repeat (5) @(negedge clk);
    demand(300);
    @(negedge clk);
    check_eq("R5 last slot valid", int'(pf_valid), 1);
    check_eq("R5 last slot addr", int'(pf_addr), 301);
    @(negedge clk);
    check_eq("R5 full drop 302", int'(pf_valid), 0);
    @(negedge clk);
    check_eq("R5 full drop 303", int'(pf_valid), 0);
    complete(101);
    demand(400);
    @(negedge clk);
    check_eq("R5 reopened addr", int'(pf_addr), 401);
    check_eq("R5 reopened valid", int'(pf_valid), 1);
    @(negedge clk);
    check_eq("R5 full again", int'(pf_valid), 0);
  endtask

  task automatic t_stall_drop();
    @(negedge clk); pf_ready = 1'b0;
    complete(102);
    complete(103);
    demand(500);
    @(negedge clk);
    check_eq("R8 stalled burst addr", int'(pf_addr), 501);
    @(negedge clk);
    check_eq("R6 stalled held", int'(pf_valid), 1);
    check_eq("R6 stalled addr", int'(pf_addr), 501);
    demand(600);
    check_eq("R7 stalled dropped", int'(pf_valid), 0);
    @(negedge clk);
    check_eq("R7 R8 restart valid", int'(pf_valid), 1);
    check_eq("R7 R8 restart addr", int'(pf_addr), 601);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_stride_basic();
    t_dup_and_stats();
    t_completion();
    t_next_n();
    t_table_full();
    t_stall_drop();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule